// File: doc/BRIEF.md
# Tenth-Order Bandpass Pulse-Density Modulator

This block converts a stream of signed high-resolution samples into a one-bit pulse-density stream whose quantization noise is pushed away from one quarter of the modulator clock rate. The loop filter is a chain of five second-order resonators. Each resonator has two poles on the unit circle. Its only coefficient is zero or a signed power of two, so each coefficient is applied as an arithmetic shift. A section with a zero coefficient puts its noise notch exactly at the quarter-rate frequency. A section with a shift coefficient moves its notch a little above or below that frequency.

The modulator produces one output bit every clock. An input sample arrives with a valid strobe, and the block holds that sample until the next strobe. Software-visible tuning goes through a write port that fills shadow registers, one code per section. A commit strobe then arms the transfer of all codes together, and the transfer happens at the next sample boundary, so the noise transfer function can be retuned while the modulator keeps running.

Top module: `sd_bp_mod`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all section states, the held sample, the error term and the active codes are zero and `pdm_o` is 1.
- R2: `pdm_o` is 1 exactly when the state of the last section is zero or positive. On each clock edge the error term becomes the held sample minus 2^(IN_W-1) when `pdm_o` is 1, and the held sample plus 2^(IN_W-1) when `pdm_o` is 0.
- R3: On each clock edge, section k takes the value x_k + c_k*s_k - p_k, and p_k takes the old s_k. Here x_0 is the error term and x_k for k>0 is the state of section k-1 before the edge. The coefficient comes from a 5-bit code: bit 4 enable, bit 3 negate, bits 2:0 shift k. The code gives c = 0 when bit 4 is clear, and otherwise ±2^-k applied as an arithmetic right shift.
- R4: The held sample loads `in_data` (two's complement) only on cycles with `in_valid` high. On other cycles, changes on `in_data` have no effect on `pdm_o`.
- R5: A section sum outside the signed ACC_W range is stored clamped to the largest or smallest value and does not wrap.
- R6: When some section has overflowed on OVF_RUN consecutive edges, the next edge clears every section state and the overflow run count. `pdm_o` then stays 1 for at least the five following cycles.
- R7: Writes to the shadow codes through `cfg_we`/`cfg_sel`/`cfg_code` do not change the output until they are committed.
- R8: `cfg_commit` arms a pending flag. The active codes take the whole shadow set on the first later edge where `in_valid` is high and the flag is set. A valid in the same cycle as the commit does not apply it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, marks a sample boundary |
| in_data | input | IN_W | Signed input sample |
| cfg_we | input | 1 | Shadow code write enable |
| cfg_sel | input | clog2(NSEC) | Section selected for the write |
| cfg_code | input | SH_W+2 | Section code {enable, negate, shift} |
| cfg_commit | input | 1 | Arms transfer of shadow codes to active codes |
| pdm_o | output | 1 | Pulse-density output bit |

## Verification
The output is compared every cycle against an arithmetic reference of the section recurrences under several input patterns. Zero input isolates the feedback alone. A DC level and a quarter-rate tone separate errors in the error term from errors in the resonator chain. Strobes that arrive every third cycle, while the data bus changes each cycle, expose a sample register that loads when it should not. Code sets with negation, with the largest and smallest shifts, left uncommitted, or committed while the strobe is low tell apart shift sign, shift amount and the timing of the code transfer. Full-scale input drives the sections into clamping and into the clearing of the run, and a reset in the middle of a run shows that the codes return to their defaults.

// File: rtl/sd_bp_mod.sv
module sd_bp_mod #(
  parameter int IN_W    = 16,
  parameter int ACC_W   = 24,
  parameter int NSEC    = 5,
  parameter int SH_W    = 3,
  parameter int OVF_RUN = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [IN_W-1:0]           in_data,
  input  logic                      cfg_we,
  input  logic [$clog2(NSEC)-1:0]   cfg_sel,
  input  logic [SH_W+1:0]           cfg_code,
  input  logic                      cfg_commit,
  output logic                      pdm_o
);
  localparam int CODE_W = SH_W + 2;
  localparam int CNT_W  = $clog2(OVF_RUN + 1);
  localparam logic signed [IN_W:0]    FSV = {2'b01, {(IN_W-1){1'b0}}};
  localparam logic signed [ACC_W+1:0] HI  = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W+1:0] LO  = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [IN_W-1:0]        u_q;
  logic signed [IN_W:0]          e_q;
  logic [NSEC-1:0][CODE_W-1:0]   shd_q, act_q;
  logic                          pend_q;
  logic signed [ACC_W-1:0]       st [NSEC];
  logic [NSEC-1:0]               ovf;
  logic [CNT_W-1:0]              run_q;

  wire clr = (run_q == CNT_W'(OVF_RUN));
  wire signed [IN_W:0] uext = {u_q[IN_W-1], u_q};
  assign pdm_o = ~st[NSEC-1][ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q    <= '0;
      e_q    <= '0;
      shd_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
      run_q  <= '0;
    end else begin
      if (in_valid) u_q <= in_data;
      e_q <= pdm_o ? uext - FSV : uext + FSV;
      if (cfg_we) shd_q[cfg_sel] <= cfg_code;
      if (in_valid && pend_q) act_q <= shd_q;
      if (cfg_commit) pend_q <= 1'b1;
      else if (in_valid) pend_q <= 1'b0;
      if (clr) run_q <= '0;
      else if (|ovf) run_q <= run_q + 1'b1;
      else run_q <= '0;
    end
  end

  for (genvar g = 0; g < NSEC; g++) begin : sec
    logic signed [ACC_W-1:0] s_r, p_r, x, t, nxt;
    logic signed [ACC_W+1:0] sum;

    if (g == 0) begin : head
      assign x = {{(ACC_W-IN_W-1){e_q[IN_W]}}, e_q};
    end else begin : link
      assign x = st[g-1];
    end

    assign t = s_r >>> act_q[g][SH_W-1:0];

    always_comb begin
      sum = {{2{x[ACC_W-1]}}, x} - {{2{p_r[ACC_W-1]}}, p_r};
      if (act_q[g][CODE_W-1])
        sum = act_q[g][CODE_W-2] ? sum - {{2{t[ACC_W-1]}}, t}
                                 : sum + {{2{t[ACC_W-1]}}, t};
    end

    assign ovf[g] = (sum > HI) || (sum < LO);
    assign nxt = (sum > HI) ? HI[ACC_W-1:0] :
                 (sum < LO) ? LO[ACC_W-1:0] : sum[ACC_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_r <= '0;
        p_r <= '0;
      end else if (clr) begin
        s_r <= '0;
        p_r <= '0;
      end else begin
        p_r <= s_r;
        s_r <= nxt;
      end
    end

    assign st[g] = s_r;
  end
endmodule

// File: rtl/sd_bp_mod_chk.sv
module sd_bp_mod_chk #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24,
  parameter int NSEC  = 5,
  parameter int SH_W  = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         pdm_o,
  input logic [IN_W-1:0]              u_q,
  input logic [IN_W:0]                e_q,
  input logic [NSEC*(SH_W+2)-1:0]     act_q,
  input logic                         clr,
  input logic [ACC_W-1:0]             last_s
);
  localparam logic [IN_W:0] FSV = {2'b01, {(IN_W-1){1'b0}}};
  logic [IN_W:0] uext;
  assign uext = {u_q[IN_W-1], u_q};

  // R4
  hold_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(u_q));

  // R2
  fb_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdm_o |=> e_q == $past(uext) - FSV);

  // R2
  fb_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pdm_o |=> e_q == $past(uext) + FSV);

  // R8
  code_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(act_q));

  // R6
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (last_s == '0) && pdm_o);
endmodule

bind sd_bp_mod sd_bp_mod_chk #(
  .IN_W(IN_W), .ACC_W(ACC_W), .NSEC(NSEC), .SH_W(SH_W)
) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pdm_o(pdm_o),
  .u_q(u_q), .e_q(e_q), .act_q(act_q), .clr(clr), .last_s(st[NSEC-1])
);

// File: tb/sd_bp_mod_test.sv
module sd_bp_mod_test;
  localparam int IN_W = 16, ACC_W = 24, NSEC = 5, SH_W = 3, OVF_RUN = 4;
  localparam longint FS   = 64'sd1 <<< (IN_W-1);
  localparam longint MAXA = (64'sd1 <<< (ACC_W-1)) - 1;
  localparam longint MINA = -(64'sd1 <<< (ACC_W-1));

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, cfg_we = 1'b0, cfg_commit = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [2:0] cfg_sel = '0;
  logic [4:0] cfg_code = '0;
  logic pdm_o;

  sd_bp_mod uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
    .cfg_commit(cfg_commit), .pdm_o(pdm_o));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, mism = 0, wmism = 0, since_clr = 99;
  logic fa, fe;

  longint ms [NSEC], mp [NSEC], me, mu;
  int mrun;
  logic [4:0] mact [NSEC], mshd [NSEC];
  bit mpend;

  task automatic model_reset();
    for (int g = 0; g < NSEC; g++) begin ms[g] = 0; mp[g] = 0; mact[g] = '0; mshd[g] = '0; end
    me = 0; mu = 0; mrun = 0; mpend = 0;
  endtask

  task automatic model_step();
    bit b, clr, any;
    longint nx [NSEC];
    longint x, t, sum;
    b = ms[NSEC-1] >= 0;
    clr = (mrun == OVF_RUN);
    any = 0;
    for (int g = 0; g < NSEC; g++) begin
      x = (g == 0) ? me : ms[g-1];
      t = ms[g] >>> mact[g][2:0];
      sum = x - mp[g];
      if (mact[g][4]) sum = mact[g][3] ? sum - t : sum + t;
      if (sum > MAXA) begin nx[g] = MAXA; any = 1; end
      else if (sum < MINA) begin nx[g] = MINA; any = 1; end
      else nx[g] = sum;
    end
    if (clr) begin
      for (int g = 0; g < NSEC; g++) begin ms[g] = 0; mp[g] = 0; end
      mrun = 0; since_clr = 0;
    end else begin
      for (int g = 0; g < NSEC; g++) begin mp[g] = ms[g]; ms[g] = nx[g]; end
      mrun = any ? mrun + 1 : 0;
      if (since_clr < 99) since_clr++;
    end
    me = mu + (b ? -FS : FS);
    if (in_valid) mu = longint'($signed(in_data));
    if (in_valid && mpend) for (int g = 0; g < NSEC; g++) mact[g] = mshd[g];
    if (cfg_we && cfg_sel < NSEC) mshd[cfg_sel] = cfg_code;
    if (cfg_commit) mpend = 1; else if (in_valid) mpend = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    logic e;
    @(negedge clk);
    e = ms[NSEC-1] >= 0;
    if (pdm_o !== e) begin
      if (mism == 0) begin fa = pdm_o; fe = e; end
      mism++;
    end
    if (since_clr < 5 && pdm_o !== 1'b1) wmism++;
  endtask

  task automatic seg_done(string req);
    check(mism == 0, req, mism == 0 ? 0 : longint'(fa), mism == 0 ? 0 : longint'(fe));
    mism = 0;
  endtask

  task automatic put_code(int sel, logic [4:0] code);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_code = code;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    check(pdm_o === 1'b1, "R1 reset output", pdm_o, 1);
  endtask

  task automatic t_zero();
    in_valid = 1'b1; in_data = '0;
    for (int i = 0; i < 150; i++) tick();
    seg_done("R2 zero input stream");
  endtask

  task automatic t_dc();
    in_valid = 1'b1; in_data = 16'sd12000;
    for (int i = 0; i < 150; i++) tick();
    seg_done("R3 dc input stream");
  endtask

  task automatic t_quarter();
    in_valid = 1'b1;
    for (int i = 0; i < 160; i++) begin
      case (i % 4)
        0: in_data = 16'sd20000;
        2: in_data = -16'sd20000;
        default: in_data = '0;
      endcase
      tick();
    end
    seg_done("R3 quarter-rate tone");
  endtask

  task automatic t_sparse();
    for (int i = 0; i < 150; i++) begin
      in_valid = (i % 3 == 0);
      in_data = 16'(i * 977 - 30000);
      tick();
    end
    in_valid = 1'b0;
    seg_done("R4 sparse strobes");
  endtask

  task automatic t_shadow();
    put_code(0, 5'b10000); put_code(1, 5'b11001); put_code(2, 5'b10111);
    in_valid = 1'b1; in_data = 16'sd5000;
    for (int i = 0; i < 100; i++) tick();
    seg_done("R7 uncommitted codes");
  endtask

  task automatic t_commit();
    put_code(3, 5'b10010); put_code(4, 5'b11011);
    in_valid = 1'b0; cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    in_valid = 1'b1; in_data = -16'sd8000;
    for (int i = 0; i < 120; i++) tick();
    seg_done("R8 commit at sample boundary");
  endtask

  task automatic t_negcoef();
    for (int g = 0; g < NSEC; g++) put_code(g, 5'b11000 | 5'(g % 4 + 1));
    in_valid = 1'b1; cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    in_data = 16'sd3000;
    for (int i = 0; i < 120; i++) tick();
    seg_done("R3 negated shifts");
  endtask

  task automatic t_bigshift();
    put_code(0, 5'b10111); put_code(1, 5'b10000); put_code(2, 5'b11111);
    put_code(3, 5'b11000); put_code(4, 5'b00101);
    cfg_commit = 1'b1; tick(); cfg_commit = 1'b0;
    tick();
    in_data = 16'sd15000;
    for (int i = 0; i < 120; i++) tick();
    seg_done("R3 extreme shift amounts");
  endtask

  task automatic t_fullscale();
    in_valid = 1'b1;
    for (int i = 0; i < 300; i++) begin
      in_data = ((i / 40) % 2 == 0) ? 16'sh7fff : 16'sh8000;
      tick();
    end
    seg_done("R5 full-scale clamping");
  endtask

  task automatic t_window();
    check(wmism == 0, "R6 output high after clear", wmism, 0);
  endtask

  task automatic t_rereset();
    in_valid = 1'b1; in_data = 16'sd9000;
    for (int i = 0; i < 30; i++) tick();
    rst_n = 1'b0;
    #1;
    check(pdm_o === 1'b1, "R1 mid-run reset output", pdm_o, 1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    mism = 0;
    for (int i = 0; i < 100; i++) tick();
    seg_done("R1 default codes after reset");
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero();
    t_dc();
    t_quarter();
    t_sparse();
    t_shadow();
    t_commit();
    t_negcoef();
    t_bigshift();
    t_fullscale();
    t_window();
    t_rereset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule